// File: doc/BRIEF.md
# Host Data Transfer Engine

This block streams bytes from a sector buffer to a host-side consumer. Before a start pulse, the surrounding register logic loads a 16-bit data address and a 12-bit byte count. The start pulse takes effect only while the output-enable level is high. The engine then reads the buffer through a simple synchronous read port and offers each byte on a valid/ready stream. Between offers it waits a programmable number of cycles. After every byte the consumer accepts, the address advances and the count steps down.

The count is kept as a low byte and a high nibble. The transfer ends when both are zero and one more byte is accepted, so a count of N moves N+1 bytes. Two active-low status levels are kept: a busy flag, which is low while a transfer runs, and an end flag, which drops when the last byte is taken and rises again on an acknowledge pulse. Dropping the output enable aborts any transfer and sets both flags high.

Back-pressure rules: once `tx_valid` rises, `tx_data` and the address hold still until `tx_ready` is seen high. If the consumer is not ready when a byte is first offered, the transfer counts as paused. The held byte still completes normally. After that, no further byte is fetched until a resume pulse arrives.

Top module: `hdx_engine`

## Requirements
- R1: A `trig` pulse with `out_en` high starts a transfer, and `busy_n` is low in the next cycle. A `trig` with `out_en` low is ignored.
- R2: The first `tx_valid` appears 3 cycles after the `trig` cycle. While the consumer is ready at each offer, offers are spaced exactly P cycles apart. P is `cyc_per_byte`, and values below 3 act as 3.
- R3: Each offered byte is the buffer word at the current address masked to its low BUF_AW bits. `mem_addr` carries those bits. `mem_rd` is high for one cycle per byte, and the data returns in the following cycle.
- R4: Each accepted byte advances the 16-bit address by one, with wrap-around. It decrements the low count byte, and when the low byte wraps from 0x00 to 0xFF it also decrements the high nibble.
- R5: A count of N moves exactly N+1 bytes. In the cycle after the final acceptance, `end_n` is 0, `busy_n` is 1, `tx_valid` is 0 and `cur_cnt` reads 0xFFF.
- R6: An `end_ack` pulse returns `end_n` to 1.
- R7: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `cur_addr` stay unchanged.
- R8: A byte first offered to a not-ready consumer pauses the transfer. After that byte is accepted, no new byte is offered and `busy_n` stays low until a `resume` pulse. The next byte then appears 3 cycles after the resume cycle. A `resume` in any other state has no effect.
- R9: With `out_en` low, the next cycle shows `tx_valid` 0, `busy_n` 1 and `end_n` 1. No byte is offered until a new trigger.
- R10: A `trig` during an active transfer restarts fetching from the current address and count, so the total number of bytes moved is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| out_en | input | 1 | Data output enable level |
| trig | input | 1 | Start pulse |
| resume | input | 1 | Resume a paused transfer |
| end_ack | input | 1 | Return the end flag to inactive |
| ld_addr | input | 1 | Load the data address |
| addr_in | input | 16 | Address load value |
| ld_cnt | input | 1 | Load the byte count |
| cnt_in | input | 12 | Count load value (bytes minus one) |
| cyc_per_byte | input | 4 | Offer period in cycles |
| mem_rd | output | 1 | Buffer read strobe |
| mem_addr | output | 14 | Buffer read address |
| mem_rdata | input | 8 | Buffer read data, one cycle after `mem_rd` |
| tx_valid | output | 1 | Byte offered |
| tx_ready | input | 1 | Consumer accepts |
| tx_data | output | 8 | Offered byte |
| busy_n | output | 1 | Transfer busy, active low |
| end_n | output | 1 | Transfer ended, active low |
| cur_addr | output | 16 | Current data address |
| cur_cnt | output | 12 | Current byte count |

## Verification
The bench runs transfers whose counts cross the low-byte borrow. A design that ended on the low byte alone would stop 256 bytes early, and one that ended one step late would move an extra byte. Some start addresses straddle the buffer-size boundary and the 16-bit wrap, which exposes a missing or wrong mask as wrong data. A consumer stalled at the first offer tests two things. Changing data during the stall breaks the hold rule, and continuing without a resume breaks the pause. Abort, mid-transfer retrigger and a period programmed below the floor catch flags left stale, restarts that reload the count, and pacing that collapses to back-to-back bytes.

// File: rtl/hdx_pkg.sv
`timescale 1ns/1ps
package hdx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LOAD,
    ST_OFFER,
    ST_GAP,
    ST_HOLD
  } hdx_state_e;

  // FETCH + LOAD + OFFER need three cycles per byte
  localparam int unsigned MIN_PERIOD = 3;
endpackage

// File: rtl/hdx_counters.sv
`timescale 1ns/1ps
module hdx_counters #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 12,
  parameter int LO_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_addr,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              ld_cnt,
  input  logic [CNT_W-1:0]  cnt_in,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic [CNT_W-1:0]  cnt,
  output logic              last
);
  localparam int HI_W = CNT_W - LO_W;

  logic [LO_W-1:0] lo_q;
  logic [HI_W-1:0] hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
    end else if (ld_addr) begin
      addr <= addr_in;
    end else if (step) begin
      addr <= addr + 1'b1;
    end
  end

  // two-stage count: low byte borrows into the high part
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (ld_cnt) begin
      lo_q <= cnt_in[LO_W-1:0];
      hi_q <= cnt_in[CNT_W-1:LO_W];
    end else if (step) begin
      lo_q <= lo_q - 1'b1;
      if (lo_q == '0) begin
        hi_q <= hi_q - 1'b1;
      end
    end
  end

  assign cnt  = {hi_q, lo_q};
  assign last = (lo_q == '0) && (hi_q == '0);

  a_r4_borrow: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld_cnt && lo_q == '0) |=>
      (lo_q == {LO_W{1'b1}}) && (hi_q == HI_W'($past(hi_q) - 1'b1)));

  a_r4_no_borrow: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld_cnt && lo_q != '0) |=> (hi_q == $past(hi_q)));

  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld_addr) |=> (addr == ADDR_W'($past(addr) + 1'b1)));
endmodule

// File: rtl/hdx_pacer.sv
`timescale 1ns/1ps
module hdx_pacer #(
  parameter int PER_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [PER_W-1:0] per_in,
  output logic             due
);
  import hdx_pkg::*;

  localparam logic [PER_W-1:0] PER_FLOOR = PER_W'(MIN_PERIOD);

  logic [PER_W-1:0] tmr_q;
  logic [PER_W-1:0] eff_per;

  assign eff_per = (per_in < PER_FLOOR) ? PER_FLOOR : per_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
    end else if (restart) begin
      tmr_q <= '0;
    end else if (tmr_q != {PER_W{1'b1}}) begin
      tmr_q <= tmr_q + 1'b1;
    end
  end

  assign due = (tmr_q >= eff_per - PER_W'(1));

  a_r2_not_due_after_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !due);
endmodule

// File: rtl/hdx_engine.sv
`timescale 1ns/1ps
module hdx_engine #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 12,
  parameter int LO_W   = 8,
  parameter int BUF_AW = 14,
  parameter int PER_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              out_en,
  input  logic              trig,
  input  logic              resume,
  input  logic              end_ack,
  input  logic              ld_addr,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              ld_cnt,
  input  logic [CNT_W-1:0]  cnt_in,
  input  logic [PER_W-1:0]  cyc_per_byte,
  output logic              mem_rd,
  output logic [BUF_AW-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  output logic              busy_n,
  output logic              end_n,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [CNT_W-1:0]  cur_cnt
);
  import hdx_pkg::*;

  hdx_state_e st_q, st_d;
  logic       stalled_q;
  logic       accept;
  logic       last;
  logic       due;
  logic       finish;
  logic [DATA_W-1:0] data_q;

  assign accept = (st_q == ST_OFFER) && tx_ready;
  assign finish = accept && last;

  hdx_counters #(
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W),
    .LO_W  (LO_W)
  ) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld_addr(ld_addr),
    .addr_in(addr_in),
    .ld_cnt (ld_cnt),
    .cnt_in (cnt_in),
    .step   (accept),
    .addr   (cur_addr),
    .cnt    (cur_cnt),
    .last   (last)
  );

  hdx_pacer #(
    .PER_W(PER_W)
  ) u_pace (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(st_d == ST_FETCH),
    .per_in (cyc_per_byte),
    .due    (due)
  );

  always_comb begin
    st_d = st_q;
    if (!out_en || finish) begin
      st_d = ST_IDLE;
    end else if (trig) begin
      st_d = ST_FETCH;
    end else begin
      unique case (st_q)
        ST_IDLE:  st_d = ST_IDLE;
        ST_FETCH: st_d = ST_LOAD;
        ST_LOAD:  st_d = ST_OFFER;
        ST_OFFER: begin
          if (tx_ready) begin
            if (stalled_q) st_d = ST_HOLD;
            else if (due)  st_d = ST_FETCH;
            else           st_d = ST_GAP;
          end
        end
        ST_GAP:   st_d = due ? ST_FETCH : ST_GAP;
        ST_HOLD:  st_d = resume ? ST_FETCH : ST_HOLD;
        default:  st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      stalled_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_d == ST_FETCH || st_d == ST_IDLE) begin
        stalled_q <= 1'b0;
      end else if (st_q == ST_OFFER && !tx_ready) begin
        stalled_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (st_q == ST_LOAD) begin
      data_q <= mem_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_n <= 1'b1;
      end_n  <= 1'b1;
    end else if (!out_en) begin
      busy_n <= 1'b1;
      end_n  <= 1'b1;
    end else if (finish) begin
      busy_n <= 1'b1;
      end_n  <= 1'b0;
    end else begin
      if (trig)    busy_n <= 1'b0;
      if (end_ack) end_n  <= 1'b1;
    end
  end

  assign mem_rd   = (st_q == ST_FETCH);
  assign mem_addr = cur_addr[BUF_AW-1:0];
  assign tx_valid = (st_q == ST_OFFER);
  assign tx_data  = data_q;

  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && out_en && !trig && !ld_addr) |=>
      (tx_valid && $stable(tx_data) && $stable(cur_addr)));

  a_r9_abort: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |=> (!tx_valid && busy_n && end_n));

  a_r1_start: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && out_en && !(tx_valid && tx_ready)) |=> !busy_n);

  a_r5_end_flags: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(end_n) |-> (busy_n && !tx_valid));

  a_r8_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HOLD && !resume && !trig) |=> !tx_valid);
endmodule

// File: tb/sim_hdx_engine.sv
`timescale 1ns/1ps
module sim_hdx_engine;
  localparam int BAW = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic out_en = 1'b0, trig = 1'b0, resume = 1'b0, end_ack = 1'b0;
  logic ld_addr = 1'b0, ld_cnt = 1'b0;
  logic [15:0] addr_in = '0;
  logic [11:0] cnt_in = '0;
  logic [3:0]  cyc_per_byte = 4'd6;
  logic        mem_rd;
  logic [BAW-1:0] mem_addr;
  logic [7:0]  mem_q = '0;
  logic        tx_valid, tx_ready = 1'b1;
  logic [7:0]  tx_data;
  logic        busy_n, end_n;
  logic [15:0] cur_addr;
  logic [11:0] cur_cnt;

  int checks = 0, errs = 0, cyc = 0;
  int n_acc = 0, last_cyc = 0, trig_cyc = 0, space_p = 6;
  bit space_on = 0, lat_on = 0;
  logic [15:0] exp_addr = '0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] fdat(input logic [15:0] a);
    int v;
    v = int'(a[BAW-1:0]) * 37 + 5;
    return v[7:0];
  endfunction

  always @(posedge clk) if (mem_rd) mem_q <= fdat(16'(mem_addr));

  hdx_engine u0 (
    .clk(clk), .rst_n(rst_n), .out_en(out_en), .trig(trig), .resume(resume),
    .end_ack(end_ack), .ld_addr(ld_addr), .addr_in(addr_in), .ld_cnt(ld_cnt),
    .cnt_in(cnt_in), .cyc_per_byte(cyc_per_byte), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_rdata(mem_q), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .busy_n(busy_n), .end_n(end_n),
    .cur_addr(cur_addr), .cur_cnt(cur_cnt)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  // accepted-byte monitor: R3 data, R4 address, R2 timing
  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      chk(tx_data == fdat(exp_addr), "R3 byte data", int'(tx_data), int'(fdat(exp_addr)));
      chk(cur_addr == exp_addr, "R4 address at accept", int'(cur_addr), int'(exp_addr));
      if (n_acc == 0 && lat_on)
        chk(cyc - trig_cyc == 3, "R2 first byte latency", cyc - trig_cyc, 3);
      if (n_acc > 0 && space_on)
        chk(cyc - last_cyc == space_p, "R2 offer spacing", cyc - last_cyc, space_p);
      last_cyc = cyc;
      n_acc++;
      exp_addr = exp_addr + 16'd1;
    end
  end

  task automatic load(input logic [15:0] a, input logic [11:0] c, input logic [3:0] p);
    ld_addr = 1; addr_in = a; ld_cnt = 1; cnt_in = c; cyc_per_byte = p;
    tick;
    ld_addr = 0; ld_cnt = 0;
    n_acc = 0; exp_addr = a;
  endtask

  task automatic pulse_trig;
    trig = 1; trig_cyc = cyc;
    tick;
    trig = 0;
  endtask

  task automatic wait_end(input int lim);
    for (int i = 0; i < lim; i++) begin
      if (end_n == 1'b0) break;
      tick;
    end
    chk(end_n == 1'b0, "R5 end flag reached", int'(end_n), 0);
  endtask

  task automatic ack_end;
    end_ack = 1;
    tick;
    end_ack = 0;
    chk(end_n == 1'b1, "R6 end acknowledged", int'(end_n), 1);
  endtask

  task automatic run_vec(input logic [15:0] a, input logic [11:0] c,
                         input logic [3:0] p, input int sp);
    load(a, c, p);
    space_on = 1; space_p = sp; lat_on = 1;
    pulse_trig;
    chk(busy_n == 1'b0, "R1 busy after start", int'(busy_n), 0);
    wait_end(6000);
    chk(n_acc == int'(c) + 1, "R5 byte total", n_acc, int'(c) + 1);
    chk(busy_n == 1'b1 && !tx_valid, "R5 idle after end", int'(busy_n), 1);
    chk(cur_cnt == 12'hFFF, "R5 count underflow", int'(cur_cnt), 'hFFF);
    chk(cur_addr == 16'(a + c + 1), "R4 final address", int'(cur_addr), int'(16'(a + c + 1)));
    ack_end;
  endtask

  // {addr, count, programmed period, expected spacing}
  localparam logic [35:0] VEC [0:5] = '{
    {16'h0010, 12'h000, 4'd6, 4'd6},
    {16'h0100, 12'h004, 4'd6, 4'd6},
    {16'h3FFE, 12'h005, 4'd3, 4'd3},
    {16'hFFFD, 12'h006, 4'd9, 4'd9},
    {16'h0200, 12'h100, 4'd3, 4'd3},
    {16'h0040, 12'h003, 4'd1, 4'd3}
  };

  initial begin
    int r;
    int held;
    logic [7:0] d0;
    logic [15:0] a0;
    repeat (3) tick;
    chk(busy_n && end_n && !tx_valid, "reset state", {busy_n, end_n, tx_valid}, 3'b110);
    rst_n = 1;
    tick;

    // R1: trigger ignored without output enable
    load(16'h0020, 12'h002, 4'd6);
    pulse_trig;
    repeat (20) tick;
    chk(n_acc == 0 && busy_n, "R1 trigger ignored when disabled", n_acc, 0);
    out_en = 1;
    tick;

    for (int i = 0; i < 6; i++)
      run_vec(VEC[i][35:20], VEC[i][19:8], VEC[i][7:4], int'(VEC[i][3:0]));

    // R7 / R8: stall at first offer, then pause until resume
    tx_ready = 0;
    load(16'h0700, 12'h005, 4'd6);
    space_on = 0; lat_on = 0;
    pulse_trig;
    for (int i = 0; i < 10; i++) begin
      if (tx_valid) break;
      tick;
    end
    d0 = tx_data; a0 = cur_addr;
    held = 0;
    for (int i = 0; i < 8; i++) begin
      tick;
      if (tx_valid && tx_data == d0 && cur_addr == a0) held++;
    end
    chk(held == 8, "R7 byte held under back-pressure", held, 8);
    tx_ready = 1;
    tick;
    repeat (30) tick;
    chk(n_acc == 1 && !tx_valid, "R8 paused after stalled byte", n_acc, 1);
    chk(busy_n == 1'b0, "R8 busy while paused", int'(busy_n), 0);
    resume = 1; r = cyc;
    tick;
    resume = 0;
    for (int i = 0; i < 20; i++) begin
      if (n_acc >= 2) break;
      tick;
    end
    chk(last_cyc - r == 3, "R8 resume latency", last_cyc - r, 3);
    wait_end(200);
    chk(n_acc == 6, "R8 total after resume", n_acc, 6);
    ack_end;

    // R8: resume while idle does nothing
    resume = 1;
    tick;
    resume = 0;
    repeat (15) tick;
    chk(n_acc == 6 && !tx_valid && busy_n, "R8 resume ignored when idle", n_acc, 6);

    // R9: abort mid-transfer
    load(16'h0900, 12'h032, 4'd6);
    space_on = 1; space_p = 6; lat_on = 1;
    pulse_trig;
    for (int i = 0; i < 100; i++) begin
      if (n_acc >= 3) break;
      tick;
    end
    out_en = 0;
    tick;
    chk(!tx_valid && busy_n && end_n, "R9 abort flags", {tx_valid, busy_n, end_n}, 3'b011);
    repeat (30) tick;
    out_en = 1;
    repeat (10) tick;
    chk(n_acc == 3 && !tx_valid, "R9 no bytes after abort", n_acc, 3);

    // R10: retrigger mid-transfer continues from current state
    load(16'h0500, 12'h009, 4'd6);
    space_on = 0; lat_on = 1;
    pulse_trig;
    for (int i = 0; i < 100; i++) begin
      if (n_acc >= 3) break;
      tick;
    end
    tick;
    pulse_trig;
    wait_end(300);
    chk(n_acc == 10, "R10 total after restart", n_acc, 10);
    chk(cur_addr == 16'h050A, "R10 final address", int'(cur_addr), 'h50A);
    ack_end;

    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    #4000000;
    chk(0, "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule